// File: doc/BRIEF.md
# Block-Transfer Mailbox Host Register Interface

This block is the host-facing register window of a block-transfer message mailbox between a host processor and a management controller. The host reaches it through a byte-wide read/write strobe interface with a two-bit offset. It fills an inbound request buffer one byte at a time. It drains an outbound response buffer one byte at a time. It passes messages back and forth through a small set of handshake flags in a control register.

On the controller side, a one-cycle request strobe announces that the host has finished a request. The controller reads the inbound bytes through a random-access read port, together with a running byte count. It writes the response through a load port, then marks the response complete with a strobe. A separate strobe raises a general event-attention flag. Message parsing and interrupt generation live in other blocks. This block exports the flag and mask state those blocks need.

Top module: `xmb_host_regif`

## Requirements
- R1: Only the two offset bits are decoded: 0 selects control, 1 selects the data port and 2 selects the mask register. A read at offset 3 returns 0xFF. A control read returns bit7 controller-busy, bit6 host-busy, bit4 event-attention and bit3 response-attention. Bits 5, 2, 1 and 0 read as zero.
- R2: A control write with bit0 set zeroes the inbound byte count. A control write with bit1 set zeroes the outbound read pointer. Neither bit is stored.
- R3: A control write with bit3 set clears response-attention, and one with bit4 set clears event-attention. A zero in either bit leaves the flag unchanged.
- R4: A control write with bit6 set inverts host-busy.
- R5: A control write with bit2 set raises controller-busy and makes `req_valid` high for exactly the following cycle.
- R6: A data-port write stores the byte at index `in_count` only while `in_count` is below IN_DEPTH. `in_count` rises by one on every data write, saturating at all ones. Bytes beyond capacity never overwrite stored bytes.
- R7: A data-port read returns the outbound byte at the read pointer while the pointer is below the response length, then advances the pointer. When the pointer reaches the length, both return to zero. With no byte pending, the read returns 0xFF and changes nothing.
- R8: `rsp_we` writes one outbound byte. `rsp_done` sets the response length to `rsp_len`, clamped to OUT_DEPTH, and zeroes the read pointer. It also clears controller-busy and sets response-attention.
- R9: An `evt_set` pulse sets event-attention.
- R10: The mask register holds the low MASK_W bits written at offset 2, reads them back zero-extended, and drives them on `mask_q`.
- R11: After reset, every flag, count, pointer, length and the mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Host register offset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from `host_addr` |
| req_valid | output | 1 | One-cycle pulse: request handed to the controller |
| in_count | output | $clog2(IN_DEPTH)+2 | Number of data-port writes since the last clear |
| in_raddr | input | $clog2(IN_DEPTH) | Controller read index into the inbound buffer |
| in_rdata | output | 8 | Inbound byte at `in_raddr` |
| rsp_we | input | 1 | Controller write strobe for one outbound byte |
| rsp_waddr | input | $clog2(OUT_DEPTH) | Outbound byte index |
| rsp_wdata | input | 8 | Outbound byte value |
| rsp_done | input | 1 | Response complete strobe |
| rsp_len | input | $clog2(OUT_DEPTH+1) | Response length in bytes, taken with `rsp_done` |
| evt_set | input | 1 | Raises event-attention |
| ctrl_busy | output | 1 | Controller-busy flag |
| host_busy | output | 1 | Host-busy flag |
| rsp_atn | output | 1 | Response-attention flag |
| evt_atn | output | 1 | Event-attention flag |
| mask_q | output | MASK_W | Stored interrupt mask |

## Verification
The bench targets the control bits whose meaning is not plain storage. Bit6 must flip host-busy on each write; a design that stores it would stay set on the second write. A zero in the attention bits must leave the flags untouched; a design that stores the written value would drop a pending attention. The outbound rewind and the automatic reset at the end of a message are read back byte by byte. A pointer that fails to reset would return stale bytes instead of 0xFF. A rewind that also cleared the length would return 0xFF too early. Overrun is driven past capacity and followed by inbound reads at index 0 and at the last index; a truncated write index would corrupt byte 0. A response length above capacity is clamped, so exactly OUT_DEPTH bytes come back before 0xFF.

// File: rtl/xmb_pkg.sv
`timescale 1ns/1ps
package xmb_pkg;
   // host window offsets
   localparam logic [1:0] OFS_CTRL = 2'd0;
   localparam logic [1:0] OFS_DATA = 2'd1;
   localparam logic [1:0] OFS_MASK = 2'd2;

   // control register bit positions (host-visible layout)
   localparam int B_CLR_IN   = 0;
   localparam int B_CLR_OUT  = 1;
   localparam int B_REQ      = 2;
   localparam int B_RSP_ATN  = 3;
   localparam int B_EVT_ATN  = 4;
   localparam int B_HOST_BSY = 6;
   localparam int B_CTRL_BSY = 7;

   localparam logic [7:0] IDLE_BYTE = 8'hFF;

   // decoded control-write commands handed to the flag logic
   typedef struct packed {
      logic req;
      logic rsp_clr;
      logic evt_clr;
      logic bsy_tgl;
   } ctrl_cmd_t;
endpackage

// File: rtl/xmb_flags.sv
`timescale 1ns/1ps
module xmb_flags
   import xmb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_we,
   input  ctrl_cmd_t cmd,
   input  logic      rsp_done,
   input  logic      evt_set,
   output logic      req_pulse,
   output logic      ctrl_busy,
   output logic      host_busy,
   output logic      rsp_atn,
   output logic      evt_atn
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_pulse <= 1'b0;
         ctrl_busy <= 1'b0;
         host_busy <= 1'b0;
         rsp_atn   <= 1'b0;
         evt_atn   <= 1'b0;
      end else begin
         req_pulse <= cmd_we && cmd.req;
         // controller-side events first; a host write in the same cycle overrides
         if (rsp_done) begin
            ctrl_busy <= 1'b0;
            rsp_atn   <= 1'b1;
         end
         if (evt_set) evt_atn <= 1'b1;
         if (cmd_we) begin
            if (cmd.rsp_clr) rsp_atn   <= 1'b0;
            if (cmd.evt_clr) evt_atn   <= 1'b0;
            if (cmd.bsy_tgl) host_busy <= ~host_busy;
            if (cmd.req)     ctrl_busy <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/xmb_in_buf.sv
`timescale 1ns/1ps
module xmb_in_buf #(
   parameter int DEPTH   = 64,
   parameter bit CNT_SAT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       we,
   input  logic [7:0]                 wdata,
   output logic [$clog2(DEPTH)+1:0]   cnt,
   input  logic [$clog2(DEPTH)-1:0]   raddr,
   output logic [7:0]                 rdata
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 2;

   logic [7:0]    mem_q [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   logic          room;

   assign room = cnt_q < CW'(DEPTH);

   if (CNT_SAT) begin : g_sat
      assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + CW'(1);
   end else begin : g_wrap
      assign cnt_inc = cnt_q + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (we && room) mem_q[cnt_q[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (we)  cnt_q <= cnt_inc;
   end

   assign cnt   = cnt_q;
   assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : 8'h00;
endmodule

// File: rtl/xmb_out_buf.sv
`timescale 1ns/1ps
module xmb_out_buf
   import xmb_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ld_we,
   input  logic [$clog2(DEPTH)-1:0]     ld_addr,
   input  logic [7:0]                   ld_data,
   input  logic                         ld_done,
   input  logic [$clog2(DEPTH+1)-1:0]   ld_len,
   input  logic                         rd_adv,
   input  logic                         rewind,
   output logic [7:0]                   rd_data
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);

   logic [7:0]    mem_q [DEPTH];
   logic [LW-1:0] ptr_q;
   logic [LW-1:0] len_q;
   logic [LW-1:0] len_clamped;
   logic          pending;
   logic [LW-1:0] ptr_nxt;

   assign pending     = ptr_q < len_q;
   assign ptr_nxt     = ptr_q + LW'(1);
   assign len_clamped = (ld_len > LW'(DEPTH)) ? LW'(DEPTH) : ld_len;

   always_ff @(posedge clk) begin
      if (ld_we && (int'(ld_addr) < DEPTH)) mem_q[ld_addr] <= ld_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         len_q <= '0;
      end else if (ld_done) begin
         ptr_q <= '0;
         len_q <= len_clamped;
      end else if (rewind) begin
         ptr_q <= '0;
      end else if (rd_adv && pending) begin
         if (ptr_nxt == len_q) begin
            ptr_q <= '0;
            len_q <= '0;
         end else begin
            ptr_q <= ptr_nxt;
         end
      end
   end

   assign rd_data = pending ? mem_q[ptr_q[AW-1:0]] : IDLE_BYTE;
endmodule

// File: rtl/xmb_host_regif.sv
`timescale 1ns/1ps
module xmb_host_regif
   import xmb_pkg::*;
#(
   parameter int IN_DEPTH  = 64,
   parameter int OUT_DEPTH = 64,
   parameter int MASK_W    = 8,
   parameter bit CNT_SAT   = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [1:0]                        host_addr,
   input  logic                              host_wr,
   input  logic                              host_rd,
   input  logic [7:0]                        host_wdata,
   output logic [7:0]                        host_rdata,
   output logic                              req_valid,
   output logic [$clog2(IN_DEPTH)+1:0]       in_count,
   input  logic [$clog2(IN_DEPTH)-1:0]       in_raddr,
   output logic [7:0]                        in_rdata,
   input  logic                              rsp_we,
   input  logic [$clog2(OUT_DEPTH)-1:0]      rsp_waddr,
   input  logic [7:0]                        rsp_wdata,
   input  logic                              rsp_done,
   input  logic [$clog2(OUT_DEPTH+1)-1:0]    rsp_len,
   input  logic                              evt_set,
   output logic                              ctrl_busy,
   output logic                              host_busy,
   output logic                              rsp_atn,
   output logic                              evt_atn,
   output logic [MASK_W-1:0]                 mask_q
);
   if (IN_DEPTH < 4 || IN_DEPTH > 255) begin : g_bad_in
      $error("IN_DEPTH must lie in 4..255");
   end
   if (OUT_DEPTH < 4 || OUT_DEPTH > 255) begin : g_bad_out
      $error("OUT_DEPTH must lie in 4..255");
   end
   if (MASK_W < 1 || MASK_W > 8) begin : g_bad_mask
      $error("MASK_W must lie in 1..8");
   end

   logic      wr_ctrl, wr_data, wr_mask, rd_data;
   ctrl_cmd_t cmd;
   logic [7:0] ctrl_rd, out_rd, mask_rd;

   assign wr_ctrl = host_wr && (host_addr == OFS_CTRL);
   assign wr_data = host_wr && (host_addr == OFS_DATA);
   assign wr_mask = host_wr && (host_addr == OFS_MASK);
   assign rd_data = host_rd && (host_addr == OFS_DATA);

   assign cmd.req     = host_wdata[B_REQ];
   assign cmd.rsp_clr = host_wdata[B_RSP_ATN];
   assign cmd.evt_clr = host_wdata[B_EVT_ATN];
   assign cmd.bsy_tgl = host_wdata[B_HOST_BSY];

   xmb_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (wr_ctrl),
      .cmd       (cmd),
      .rsp_done  (rsp_done),
      .evt_set   (evt_set),
      .req_pulse (req_valid),
      .ctrl_busy (ctrl_busy),
      .host_busy (host_busy),
      .rsp_atn   (rsp_atn),
      .evt_atn   (evt_atn)
   );

   xmb_in_buf #(.DEPTH(IN_DEPTH), .CNT_SAT(CNT_SAT)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_ctrl && host_wdata[B_CLR_IN]),
      .we    (wr_data),
      .wdata (host_wdata),
      .cnt   (in_count),
      .raddr (in_raddr),
      .rdata (in_rdata)
   );

   xmb_out_buf #(.DEPTH(OUT_DEPTH)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_we   (rsp_we),
      .ld_addr (rsp_waddr),
      .ld_data (rsp_wdata),
      .ld_done (rsp_done),
      .ld_len  (rsp_len),
      .rd_adv  (rd_data),
      .rewind  (wr_ctrl && host_wdata[B_CLR_OUT]),
      .rd_data (out_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= host_wdata[MASK_W-1:0];
   end

   if (MASK_W == 8) begin : g_mask_full
      assign mask_rd = mask_q;
   end else begin : g_mask_pad
      assign mask_rd = {{(8-MASK_W){1'b0}}, mask_q};
   end

   always_comb begin
      ctrl_rd             = 8'h00;
      ctrl_rd[B_CTRL_BSY] = ctrl_busy;
      ctrl_rd[B_HOST_BSY] = host_busy;
      ctrl_rd[B_EVT_ATN]  = evt_atn;
      ctrl_rd[B_RSP_ATN]  = rsp_atn;
   end

   always_comb begin
      case (host_addr)
         OFS_CTRL: host_rdata = ctrl_rd;
         OFS_DATA: host_rdata = out_rd;
         OFS_MASK: host_rdata = mask_rd;
         default:  host_rdata = IDLE_BYTE;
      endcase
   end
endmodule

// File: rtl/xmb_host_regif_chk.sv
`timescale 1ns/1ps
module xmb_host_regif_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    host_addr,
   input logic          host_wr,
   input logic          host_rd,
   input logic          wd_req,
   input logic          wd_rsp_clr,
   input logic          wd_tgl,
   input logic [7:0]    host_rdata,
   input logic          req_valid,
   input logic [CW-1:0] in_count,
   input logic          rsp_done,
   input logic          ctrl_busy,
   input logic          host_busy,
   input logic          rsp_atn
);
   logic ctrl_w;
   assign ctrl_w = host_wr && (host_addr == 2'd0);

   // R5: request command raises busy and the strobe next cycle
   a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_w && wd_req) |=> (req_valid && ctrl_busy));

   // R5: no strobe without a request command
   a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_w && wd_req) |=> !req_valid);

   // R4: host-busy flips on each toggle command
   a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_w && wd_tgl) |=> (host_busy != $past(host_busy)));

   // R3: clear command drops response attention
   a_r3_rsp_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_w && wd_rsp_clr && !rsp_done) |=> !rsp_atn);

   // R8: response completion hands the mailbox back
   a_r8_rsp_done: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !ctrl_w) |=> (rsp_atn && !ctrl_busy));

   // R1: unmapped offset reads as all ones
   a_r1_gap_read: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 2'd3) |-> (host_rdata == 8'hFF));

   // R6: every data write advances the count until saturation
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd1 && !(&in_count))
      |=> (in_count == CW'($past(in_count) + CW'(1))));
endmodule

bind xmb_host_regif xmb_host_regif_chk #(.CW($clog2(IN_DEPTH) + 2)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .wd_req     (host_wdata[2]),
   .wd_rsp_clr (host_wdata[3]),
   .wd_tgl     (host_wdata[6]),
   .host_rdata (host_rdata),
   .req_valid  (req_valid),
   .in_count   (in_count),
   .rsp_done   (rsp_done),
   .ctrl_busy  (ctrl_busy),
   .host_busy  (host_busy),
   .rsp_atn    (rsp_atn)
);

// File: tb/xmb_host_regif_tb_top.sv
`timescale 1ns/1ps
module xmb_host_regif_tb_top;
   localparam int IN_DEPTH  = 64;
   localparam int OUT_DEPTH = 64;
   localparam int CW = $clog2(IN_DEPTH) + 2;
   localparam int IA = $clog2(IN_DEPTH);
   localparam int OA = $clog2(OUT_DEPTH);
   localparam int LW = $clog2(OUT_DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    host_addr = '0;
   logic          host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]    host_wdata = '0;
   logic [7:0]    host_rdata;
   logic          req_valid;
   logic [CW-1:0] in_count;
   logic [IA-1:0] in_raddr = '0;
   logic [7:0]    in_rdata;
   logic          rsp_we = 1'b0;
   logic [OA-1:0] rsp_waddr = '0;
   logic [7:0]    rsp_wdata = '0;
   logic          rsp_done = 1'b0;
   logic [LW-1:0] rsp_len = '0;
   logic          evt_set = 1'b0;
   logic          ctrl_busy, host_busy, rsp_atn, evt_atn;
   logic [7:0]    mask_q;

   int checks = 0, errors = 0, pulses = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   xmb_host_regif #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .req_valid(req_valid), .in_count(in_count), .in_raddr(in_raddr),
      .in_rdata(in_rdata), .rsp_we(rsp_we), .rsp_waddr(rsp_waddr),
      .rsp_wdata(rsp_wdata), .rsp_done(rsp_done), .rsp_len(rsp_len),
      .evt_set(evt_set), .ctrl_busy(ctrl_busy), .host_busy(host_busy),
      .rsp_atn(rsp_atn), .evt_atn(evt_atn), .mask_q(mask_q)
   );

   always @(negedge clk) if (req_valid) pulses++;

   // vector: {req[3:0], op[1:0], addr[1:0], data[7:0], expected[7:0]}
   // op 0 = host write, 1 = host read and compare, 2 = compare in_count
   localparam int NV = 20;
   localparam logic [23:0] VEC [NV] = '{
      {4'd2,  2'd0, 2'd0, 8'h01, 8'h00},  // R2 clear inbound
      {4'd6,  2'd0, 2'd1, 8'h03, 8'h00},  // R6
      {4'd6,  2'd0, 2'd1, 8'h18, 8'h00},  // R6
      {4'd6,  2'd0, 2'd1, 8'h22, 8'h00},  // R6
      {4'd6,  2'd0, 2'd1, 8'h36, 8'h00},  // R6
      {4'd6,  2'd2, 2'd0, 8'h00, 8'd4},   // R6 count of four
      {4'd1,  2'd1, 2'd0, 8'h00, 8'h00},  // R1 idle control
      {4'd5,  2'd0, 2'd0, 8'h04, 8'h00},  // R5 request
      {4'd5,  2'd1, 2'd0, 8'h00, 8'h80},  // R5 controller busy
      {4'd4,  2'd0, 2'd0, 8'h40, 8'h00},  // R4 toggle on
      {4'd4,  2'd1, 2'd0, 8'h00, 8'hC0},  // R4
      {4'd4,  2'd0, 2'd0, 8'h40, 8'h00},  // R4 toggle off
      {4'd4,  2'd1, 2'd0, 8'h00, 8'h80},  // R4
      {4'd1,  2'd1, 2'd3, 8'h00, 8'hFF},  // R1 gap offset
      {4'd7,  2'd1, 2'd1, 8'h00, 8'hFF},  // R7 nothing pending
      {4'd10, 2'd0, 2'd2, 8'h03, 8'h00},  // R10
      {4'd10, 2'd1, 2'd2, 8'h00, 8'h03},  // R10
      {4'd2,  2'd0, 2'd0, 8'h01, 8'h00},  // R2 clear again
      {4'd2,  2'd2, 2'd0, 8'h00, 8'd0},   // R2 count zero
      {4'd2,  2'd1, 2'd0, 8'h00, 8'h80}   // R2 clear bit not stored
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic hwr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] v;
      hrd(a, v);
      chk(tag, 32'(v), 32'(exp));
   endtask

   task automatic bk_load(input int idx, input logic [7:0] d);
      @(negedge clk);
      rsp_waddr = OA'(idx); rsp_wdata = d; rsp_we = 1'b1;
      @(negedge clk);
      rsp_we = 1'b0;
   endtask

   task automatic bk_done(input int len);
      @(negedge clk);
      rsp_len = LW'(len); rsp_done = 1'b1;
      @(negedge clk);
      rsp_done = 1'b0;
   endtask

   task automatic in_chk(input string tag, input int idx, input logic [7:0] exp);
      @(negedge clk);
      in_raddr = IA'(idx);
      #1 chk(tag, 32'(in_rdata), 32'(exp));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      rd_chk("R11 control", 2'd0, 8'h00);
      rd_chk("R11 mask", 2'd2, 8'h00);
      rd_chk("R11 data empty", 2'd1, 8'hFF);
      #1 chk("R11 count", 32'(in_count), 0);
      chk("R11 req_valid", 32'(req_valid), 0);

      for (int i = 0; i < NV; i++) begin
         logic [3:0] rq;
         logic [1:0] op, ad;
         logic [7:0] dt, ex;
         logic [7:0] v;
         {rq, op, ad, dt, ex} = VEC[i];
         case (op)
            2'd0: hwr(ad, dt);
            2'd1: begin
               hrd(ad, v);
               chk($sformatf("R%0d vec %0d", rq, i), 32'(v), 32'(ex));
            end
            default: begin
               @(negedge clk);
               #1 chk($sformatf("R%0d vec %0d count", rq, i), 32'(in_count), 32'(ex));
            end
         endcase
      end

      // R6 stored request bytes survive the count clear
      in_chk("R6 inbound byte 1", 1, 8'h18);
      in_chk("R6 inbound byte 2", 2, 8'h22);
      // R5 exactly one strobe from the single request
      chk("R5 strobe count", 32'(pulses), 1);
      chk("R10 mask_q port", 32'(mask_q), 32'h03);

      // R8 response load
      bk_load(0, 8'hA1);
      bk_load(1, 8'hA2);
      bk_load(2, 8'hA3);
      bk_done(3);
      rd_chk("R8 control after done", 2'd0, 8'h08);
      rd_chk("R7 first byte", 2'd1, 8'hA1);
      rd_chk("R7 second byte", 2'd1, 8'hA2);
      hwr(2'd0, 8'h02);  // R2 rewind
      rd_chk("R2 rewind byte 0", 2'd1, 8'hA1);
      rd_chk("R7 byte 1", 2'd1, 8'hA2);
      rd_chk("R7 byte 2", 2'd1, 8'hA3);
      rd_chk("R7 end of message", 2'd1, 8'hFF);
      hwr(2'd0, 8'h02);
      rd_chk("R7 length reset at end", 2'd1, 8'hFF);

      // R3 zero has no effect, one clears
      hwr(2'd0, 8'h00);
      rd_chk("R3 zero keeps attention", 2'd0, 8'h08);
      hwr(2'd0, 8'h08);
      rd_chk("R3 response attention cleared", 2'd0, 8'h00);

      // R9 event attention
      @(negedge clk); evt_set = 1'b1;
      @(negedge clk); evt_set = 1'b0;
      rd_chk("R9 event attention set", 2'd0, 8'h10);
      hwr(2'd0, 8'h08);
      rd_chk("R3 other clear leaves event", 2'd0, 8'h10);
      hwr(2'd0, 8'h10);
      rd_chk("R3 event attention cleared", 2'd0, 8'h00);

      // R6 overrun past capacity
      hwr(2'd0, 8'h01);
      for (int i = 0; i < IN_DEPTH + 3; i++) hwr(2'd1, 8'(i) ^ 8'h5A);
      @(negedge clk);
      #1 chk("R6 overrun count", 32'(in_count), IN_DEPTH + 3);
      in_chk("R6 first byte intact", 0, 8'h5A);
      in_chk("R6 last stored byte", IN_DEPTH - 1, 8'(IN_DEPTH - 1) ^ 8'h5A);

      // R8 length clamp
      for (int i = 0; i < OUT_DEPTH; i++) bk_load(i, 8'(i + 7));
      bk_done(OUT_DEPTH + 20);
      for (int i = 0; i < OUT_DEPTH; i++) rd_chk("R8 clamped stream", 2'd1, 8'(i + 7));
      rd_chk("R8 clamp ends at depth", 2'd1, 8'hFF);

      finish_run();
   end
endmodule